// File: doc/BRIEF.md
# BCH Error-Position Corrector

This block sits behind a BCH decoder that reports up to eight bit-error positions for one 512-byte sector. The decoder's result arrives as three 32-bit position words and one status word. The status word carries the error count and the top byte of the last position. On a start pulse the block captures all four words. It then applies each reported position to a sector copy held in a local byte RAM by inverting the addressed bit, and reports how many bits it changed.

A count of zero finishes at once with nothing changed. A count above the decoder's correcting power raises an uncorrectable flag, so that the surrounding logic can run its erased-page test instead. In both cases the buffer is left alone. Outside a correction run, the sector RAM is filled and drained through a plain byte port.

Top module: `bch_loc_fix`

## Requirements
- R1: The error count is bits 13:10 of `err_status`, captured on an accepted start. A count of 0 ends the run with `fixed_cnt` = 0, `uncorrectable` = 0 and the buffer unchanged. All other status bits outside 23:16 are ignored.
- R2: A count of 9 or more ends the run with `uncorrectable` = 1, `fixed_cnt` = 0 and the buffer unchanged.
- R3: The positions are packed into the 104-bit value {`err_status`[23:16], `err_word3`, `err_word2`, `err_word1`}. Position i (0..7) occupies bits 13*i+12 down to 13*i, so positions 2, 4 and 7 straddle word boundaries.
- R4: Each 13-bit position is XORed with 3 to form a bit address a. The bit changed is bit a[2:0] of byte a[11:3] of the sector RAM.
- R5: A bit address of 4096 or more is skipped: nothing is written and nothing is counted.
- R6: Only positions 0 to count-1 are used. `fixed_cnt` equals the number of positions among them whose bit address is in range.
- R7: Let the start be sampled at clock edge E. `done` is high for exactly one cycle, after edge E + S + 2F, where S is the number of skipped positions and F the number of applied positions (S = F = 0 for counts of 0 or above 8). `fixed_cnt` and `uncorrectable` hold their values until the next accepted start.
- R8: `busy` is high from the edge after an accepted start through the `done` cycle. A `start` or a host write while `busy` is high has no effect.
- R9: Flips are applied in position order, each as a complete read-modify-write, so a position reported twice leaves its bit unchanged while counting twice.
- R10: While idle, `buf_we` writes `buf_wdata` to byte `buf_addr`, and `buf_rdata` returns the byte at `buf_addr` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a correction run (ignored while busy) |
| err_word1 | input | 32 | Packed positions, bits 31:0 |
| err_word2 | input | 32 | Packed positions, bits 63:32 |
| err_word3 | input | 32 | Packed positions, bits 95:64 |
| err_status | input | 32 | Count in 13:10, packed positions bits 103:96 in 23:16 |
| buf_we | input | 1 | Host byte write strobe (idle only) |
| buf_addr | input | 9 | Host byte address |
| buf_wdata | input | 8 | Host write byte |
| buf_rdata | output | 8 | Byte read at the previous cycle's address |
| fixed_cnt | output | 4 | Number of bits inverted by the last run |
| uncorrectable | output | 1 | Last run had a count above 8 |
| done | output | 1 | One-cycle end-of-run pulse |
| busy | output | 1 | Run in progress |

## Verification
The bench builds the block with its default parameters: a 512-byte sector, eight 13-bit positions and a 4-bit count. These values make every packing boundary reachable: positions 2, 4 and 7 straddle a word, and addresses 4095 and 4096 sit on either side of the data-area limit. Counts from 0 to 15 cover the empty case, the full eight-position case and the uncorrectable range. A full readback of the sector after each run shows that unused positions, out-of-range positions and positions repeated within a run all end up as R6, R5 and R9 require.

// File: rtl/bchc_pkg.sv
package bchc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_FLIP = 2'd2,
    ST_DONE = 2'd3
  } bchc_state_e;
endpackage

// File: rtl/bchc_unpack.sv
module bchc_unpack #(
  parameter int IDX_W   = 13,
  parameter int NUM_IDX = 8,
  parameter int FLIP_MASK = 3
) (
  input  logic [NUM_IDX*IDX_W-1:0]          packed_vec,
  output logic [NUM_IDX-1:0][IDX_W-1:0]     bit_addr
);
  // Each position is a plain 13-bit slice of the packed value; the two
  // low bits are inverted to turn the decoder's index into a bit address.
  for (genvar g = 0; g < NUM_IDX; g++) begin : g_slice
    assign bit_addr[g] = packed_vec[g*IDX_W +: IDX_W] ^ IDX_W'(FLIP_MASK);
  end
endmodule

// File: rtl/bchc_sector_ram.sv
module bchc_sector_ram #(
  parameter int DEPTH = 512,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end
    rdata <= mem[addr];
  end
endmodule

// File: rtl/bchc_seq.sv
module bchc_seq
  import bchc_pkg::*;
#(
  parameter int IDX_W        = 13,
  parameter int NUM_IDX      = 8,
  parameter int MAX_ERR      = 8,
  parameter int CNT_W        = 4,
  parameter int SECTOR_BYTES = 512,
  parameter int DW           = 8,
  localparam int AW          = $clog2(SECTOR_BYTES),
  localparam int IW          = $clog2(NUM_IDX),
  localparam int SECTOR_BITS = SECTOR_BYTES * DW
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          accept,
  input  logic [CNT_W-1:0]              cnt_in,
  input  logic [NUM_IDX-1:0][IDX_W-1:0] bit_addr,
  input  logic [DW-1:0]                 ram_rdata,
  output logic [AW-1:0]                 ram_addr,
  output logic                          ram_we,
  output logic [DW-1:0]                 ram_wdata,
  output logic [CNT_W-1:0]              fixed_cnt,
  output logic                          uncorr,
  output logic                          done,
  output logic                          busy
);
  bchc_state_e      state_q, state_d;
  logic [IW-1:0]    idx_q,   idx_d;
  logic [CNT_W-1:0] num_q,   num_d;
  logic [CNT_W-1:0] cnt_q,   cnt_d;
  logic             unc_q,   unc_d;

  logic [IDX_W-1:0] cur;
  logic             in_range;
  logic             last;

  assign cur      = bit_addr[idx_q];
  assign in_range = int'(cur) < SECTOR_BITS;
  assign last     = (CNT_W'(idx_q) == (num_q - CNT_W'(1)));

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    num_d     = num_q;
    cnt_d     = cnt_q;
    unc_d     = unc_q;
    ram_we    = 1'b0;
    ram_addr  = cur[AW+2:3];
    ram_wdata = ram_rdata ^ (DW'(1) << cur[2:0]);
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          num_d = cnt_in;
          idx_d = '0;
          cnt_d = '0;
          unc_d = 1'b0;
          if (cnt_in == '0) begin
            state_d = ST_DONE;
          end else if (cnt_in > CNT_W'(MAX_ERR)) begin
            unc_d   = 1'b1;
            state_d = ST_DONE;
          end else begin
            state_d = ST_SCAN;
          end
        end
      end
      ST_SCAN: begin
        if (in_range) begin
          state_d = ST_FLIP;
        end else if (last) begin
          state_d = ST_DONE;
        end else begin
          idx_d = idx_q + IW'(1);
        end
      end
      ST_FLIP: begin
        ram_we = 1'b1;
        cnt_d  = cnt_q + CNT_W'(1);
        if (last) begin
          state_d = ST_DONE;
        end else begin
          idx_d   = idx_q + IW'(1);
          state_d = ST_SCAN;
        end
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      num_q   <= '0;
      cnt_q   <= '0;
      unc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      num_q   <= num_d;
      cnt_q   <= cnt_d;
      unc_q   <= unc_d;
    end
  end

  assign fixed_cnt = cnt_q;
  assign uncorr    = unc_q;
  assign done      = (state_q == ST_DONE);
  assign busy      = (state_q != ST_IDLE);

  // R7: end-of-run strobe lasts a single cycle
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2: an uncorrectable run never reports applied flips
  p_unc_zero_cnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    uncorr |-> (fixed_cnt == '0));
  // R6: applied flips never exceed the correcting power
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fixed_cnt <= CNT_W'(MAX_ERR));
  // R4/R9: a write always follows the read of the same byte
  p_write_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ($past(state_q) == ST_SCAN) && $stable(idx_q));
  // R5: nothing outside the data area is ever written
  p_write_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> in_range);
endmodule

// File: rtl/bch_loc_fix.sv
module bch_loc_fix #(
  parameter int WORD_W       = 32,
  parameter int IDX_W        = 13,
  parameter int NUM_IDX      = 8,
  parameter int MAX_ERR      = 8,
  parameter int CNT_W        = 4,
  parameter int CNT_LSB      = 10,
  parameter int TOP_LSB      = 16,
  parameter int SECTOR_BYTES = 512,
  localparam int DW          = 8,
  localparam int AW          = $clog2(SECTOR_BYTES),
  localparam int PACK_W      = NUM_IDX * IDX_W,
  localparam int TOP_W       = PACK_W - 3 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] err_word1,
  input  logic [WORD_W-1:0] err_word2,
  input  logic [WORD_W-1:0] err_word3,
  input  logic [WORD_W-1:0] err_status,
  input  logic              buf_we,
  input  logic [AW-1:0]     buf_addr,
  input  logic [DW-1:0]     buf_wdata,
  output logic [DW-1:0]     buf_rdata,
  output logic [CNT_W-1:0]  fixed_cnt,
  output logic              uncorrectable,
  output logic              done,
  output logic              busy
);
  // Reset: asserted asynchronously, released on a clock edge
  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  logic accept;
  assign accept = start & ~busy;

  // Captured position words (clock enable = accept)
  logic [WORD_W-1:0] w1_q, w2_q, w3_q;
  logic [TOP_W-1:0]  top_q;
  logic [WORD_W-1:0] w1_d, w2_d, w3_d;
  logic [TOP_W-1:0]  top_d;

  always_comb begin
    w1_d  = w1_q;
    w2_d  = w2_q;
    w3_d  = w3_q;
    top_d = top_q;
    if (accept) begin
      w1_d  = err_word1;
      w2_d  = err_word2;
      w3_d  = err_word3;
      top_d = err_status[TOP_LSB +: TOP_W];
    end
  end

  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2) begin
      w1_q  <= '0;
      w2_q  <= '0;
      w3_q  <= '0;
      top_q <= '0;
    end else begin
      w1_q  <= w1_d;
      w2_q  <= w2_d;
      w3_q  <= w3_d;
      top_q <= top_d;
    end
  end

  logic [NUM_IDX-1:0][IDX_W-1:0] bit_addr;

  bchc_unpack #(
    .IDX_W   (IDX_W),
    .NUM_IDX (NUM_IDX),
    .FLIP_MASK (3)
  ) u_unpack (
    .packed_vec ({top_q, w3_q, w2_q, w1_q}),
    .bit_addr   (bit_addr)
  );

  logic [AW-1:0] seq_addr, ram_addr;
  logic          seq_we,   ram_we;
  logic [DW-1:0] seq_wdata, ram_wdata, ram_rdata;

  bchc_seq #(
    .IDX_W        (IDX_W),
    .NUM_IDX      (NUM_IDX),
    .MAX_ERR      (MAX_ERR),
    .CNT_W        (CNT_W),
    .SECTOR_BYTES (SECTOR_BYTES),
    .DW           (DW)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_s2),
    .accept    (accept),
    .cnt_in    (err_status[CNT_LSB +: CNT_W]),
    .bit_addr  (bit_addr),
    .ram_rdata (ram_rdata),
    .ram_addr  (seq_addr),
    .ram_we    (seq_we),
    .ram_wdata (seq_wdata),
    .fixed_cnt (fixed_cnt),
    .uncorr    (uncorrectable),
    .done      (done),
    .busy      (busy)
  );

  // Port ownership: the sequencer during a run, the host otherwise
  assign ram_addr  = busy ? seq_addr  : buf_addr;
  assign ram_we    = busy ? seq_we    : buf_we;
  assign ram_wdata = busy ? seq_wdata : buf_wdata;

  bchc_sector_ram #(
    .DEPTH (SECTOR_BYTES),
    .DW    (DW)
  ) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_rdata)
  );

  assign buf_rdata = ram_rdata;

  // R8: a start during a run leaves the captured positions untouched
  p_capture_hold_r8: assert property (@(posedge clk) disable iff (!rst_s2)
    (busy && start) |=> ($stable(w1_q) && $stable(top_q)));
  // R8: the run ends in the busy phase, then the block goes idle
  p_done_then_idle_r8: assert property (@(posedge clk) disable iff (!rst_s2)
    done |-> busy ##1 !busy);
endmodule

// File: tb/sim_bch_loc_fix.sv
module sim_bch_loc_fix;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] w1, w2, w3, ws;
  logic        buf_we;
  logic [8:0]  buf_addr;
  logic [7:0]  buf_wdata;
  logic [7:0]  buf_rdata;
  logic [3:0]  fixed_cnt;
  logic        uncorrectable, done, busy;

  always #2.5 clk = ~clk;

  bch_loc_fix u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .err_word1(w1), .err_word2(w2), .err_word3(w3), .err_status(ws),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .buf_rdata(buf_rdata), .fixed_cnt(fixed_cnt),
    .uncorrectable(uncorrectable), .done(done), .busy(busy)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] mirror [512];

  localparam int NV = 8;
  // positions packed as {p7,...,p0}; count; expected applied; expected flag
  localparam logic [103:0] T_POS [NV] = '{
    {13'd11, 13'd22, 13'd33, 13'd44, 13'd55, 13'd66, 13'd77, 13'd88},
    {13'd101, 13'd102, 13'd103, 13'd104, 13'd105, 13'd106, 13'd107, 13'd108},
    {8{13'd200}},
    {{7{13'h0321}}, 13'd0},
    {13'd63, 13'd3000, 13'd8191, 13'd1234, 13'd4099, 13'd4092, 13'd777, 13'd5},
    {{5{13'd7}}, 13'd51, 13'd50, 13'd50},
    {{6{13'd9}}, 13'd6000, 13'd4096},
    {{4{13'h0100}}, 13'h0ABC, 13'h0FFF, 13'h0001, 13'h0555}
  };
  localparam logic [3:0] T_CNT  [NV] = '{4'd0, 4'd9, 4'd15, 4'd1, 4'd8, 4'd3, 4'd2, 4'd4};
  localparam logic [3:0] T_EXPC [NV] = '{4'd0, 4'd0, 4'd0, 4'd1, 4'd6, 4'd3, 4'd0, 4'd4};
  localparam logic       T_EXPU [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  task automatic host_write(input int a, input logic [7:0] d);
    @(negedge clk);
    buf_we = 1'b1; buf_addr = 9'(a); buf_wdata = d;
    @(negedge clk);
    buf_we = 1'b0;
  endtask

  task automatic host_read(input int a, output logic [7:0] d);
    @(negedge clk);
    buf_addr = 9'(a);
    @(negedge clk);
    d = buf_rdata;
  endtask

  task automatic fill_buffer(input int seed);
    for (int i = 0; i < 512; i++) begin
      mirror[i] = 8'((i * 7 + seed) & 8'hFF);
      host_write(i, mirror[i]);
    end
  endtask

  task automatic compare_buffer(input string req);
    int bad = 0;
    logic [7:0] d;
    for (int i = 0; i < 512; i++) begin
      host_read(i, d);
      if (d !== mirror[i]) bad++;
    end
    chk(req, 32'(bad), 32'd0);
  endtask

  // Bench model of R3/R4/R5/R6/R9: updates the mirror and returns the latency
  function automatic int model(input logic [103:0] pos, input logic [3:0] n);
    int lat = 0;
    if (n == 0 || n > 8) return 0;
    for (int i = 0; i < int'(n); i++) begin
      int a;
      a = int'(pos[13*i +: 13]) ^ 3;
      if (a < 4096) begin
        mirror[a / 8][a % 8] = ~mirror[a / 8][a % 8];
        lat += 2;
      end else begin
        lat += 1;
      end
    end
    return lat;
  endfunction

  // Start a run; optionally poke start and a host write mid-run (R8)
  task automatic run(input logic [103:0] pos, input logic [3:0] n,
                     input logic poke, output int lat);
    @(negedge clk);
    w1 = pos[31:0]; w2 = pos[63:32]; w3 = pos[95:64];
    ws = {8'hC3, pos[103:96], 2'b11, n, 10'h3A5};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 200) begin
      if (poke && lat == 3) begin
        start = 1'b1; ws = 32'h0; w1 = 32'hFFFF_FFFF;
        buf_we = 1'b1; buf_addr = 9'd100; buf_wdata = ~mirror[100];
      end else begin
        start = 1'b0; buf_we = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0; buf_we = 1'b0;
  endtask

  initial begin
    int lat, exp_lat;
    logic [7:0] d;
    rst_n = 1'b0; start = 1'b0; buf_we = 1'b0; buf_addr = '0; buf_wdata = '0;
    w1 = '0; w2 = '0; w3 = '0; ws = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    chk("R7 reset done", 32'(done), 32'd0);
    chk("R8 reset busy", 32'(busy), 32'd0);
    chk("R6 reset count", 32'(fixed_cnt), 32'd0);
    chk("R2 reset flag", 32'(uncorrectable), 32'd0);

    // R10: host write then read
    host_write(3, 8'h5A);
    host_read(3, d);
    chk("R10 host readback", 32'(d), 32'h5A);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      fill_buffer(v * 13 + 1);
      exp_lat = model(T_POS[v], T_CNT[v]);
      run(T_POS[v], T_CNT[v], 1'b0, lat);
      chk($sformatf("R7 latency v%0d", v), 32'(lat), 32'(exp_lat));
      chk($sformatf("R6 R1 applied count v%0d", v), 32'(fixed_cnt), 32'(T_EXPC[v]));
      chk($sformatf("R2 flag v%0d", v), 32'(uncorrectable), 32'(T_EXPU[v]));
      @(negedge clk);
      chk($sformatf("R7 single pulse v%0d", v), 32'(done), 32'd0);
      compare_buffer($sformatf("R3 R4 R5 R9 sector v%0d", v));
      chk($sformatf("R7 result held v%0d", v), 32'(fixed_cnt), 32'(T_EXPC[v]));
    end

    // R8: start and host write during a run are ignored
    fill_buffer(77);
    exp_lat = model(T_POS[4], T_CNT[4]);
    run(T_POS[4], T_CNT[4], 1'b1, lat);
    chk("R8 latency with mid-run start", 32'(lat), 32'(exp_lat));
    chk("R8 count with mid-run start", 32'(fixed_cnt), 32'd6);
    repeat (3) @(negedge clk);
    chk("R8 no second run", 32'(busy), 32'd0);
    host_read(100, d);
    chk("R8 host write ignored while busy", 32'(d), 32'(mirror[100]));
    compare_buffer("R8 sector after pokes");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule